// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Control

This block models a small byte-wide one-time-programmable memory together with the control logic that selects its operating mode. From an active-low chip enable, an active-low output enable, and two digital flags that stand in for high voltages, it decodes several modes. The first flag sits on the output-enable pin and means programming voltage. The second sits on address bit 9 and selects identification. The decoded modes are read/verify, standby, output-off, program, program-inhibit and identification.

The array starts fully erased, with every bit at one. A program cycle can only clear bits, because the incoming byte is ANDed into the stored one. Each entry into program mode gives exactly one write on the next rising clock edge, however long the strobe is held.

In identification mode the block returns fixed identifier bytes instead of array contents. The identifiers are generated with odd parity, and a continuation code is returned when address bit 1 is low. The output bus is never tri-stated. A drive flag marks when the bus would be actively driven, and the bus reads zero whenever that flag is low.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset is released, every location reads 0xFF in read mode.
- R2: With ce_ni=0, oe_ni=0, vpp_hi_i=0 and id_hi_i=0, drive_o is 1 and data_o equals the byte stored at addr_i.
- R3: With ce_ni=1, drive_o is 0 whatever oe_ni, vpp_hi_i or id_hi_i are. Whenever drive_o is 0, data_o is 0x00.
- R4: With ce_ni=0, oe_ni=1 and no flag set, drive_o is 0.
- R5: With vpp_hi_i=1 and ce_ni=0, the first rising clock edge in that state replaces the byte at addr_i with (stored AND data_i), and drive_o stays 0 during program mode.
- R6: While program mode is held over further clock edges, no further write happens until program mode has been left and entered again.
- R7: With vpp_hi_i=1 and ce_ni=1 (program inhibit), no location changes.
- R8: A write never turns a stored 0 bit into 1, so programming 0xFF leaves a byte unchanged.
- R9: With id_hi_i=1, ce_ni=0, oe_ni=0, vpp_hi_i=0 and addr_i[1]=1, data_o is the manufacturer byte when addr_i[0]=0 and the device byte when addr_i[0]=1. With the defaults these are 0x2A and 0x91.
- R10: In identification mode with addr_i[1]=0, data_o is 0x7F.
- R11: Both identifier bytes have odd parity over all 8 bits. Bit 7 is the computed parity bit and bits 6..0 are the parameter codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes happen on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; erases the array to all ones |
| addr_i | input | ADDR_W | Byte address; bits 1 and 0 also select the identifier |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | Programming-voltage flag on the output-enable pin |
| id_hi_i | input | 1 | Identification-voltage flag on address bit 9 |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Read or identifier byte; zero when not driven |
| drive_o | output | 1 | High when the output bus would be actively driven |

## Verification
The hardest situation to reach from the ports is a program strobe that stays held over several clock edges while data_i changes underneath it. Only the first edge may write, and the later data must leave no trace. The stimulus holds program mode across consecutive vectors with different data, then leaves program mode and reads the location back. Further vectors re-enter program mode on the same address with 0xFF and with a partial mask, which shows that cleared bits cannot return to one. The same approach shows that an inhibited strobe with ce_ni high writes nothing.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CONT_CODE = 8'h7F;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_PROGRAM,
    MODE_OUT_OFF,
    MODE_ID,
    MODE_READ
  } mode_e;

  // bit 7 chosen so the whole byte has odd parity
  function automatic logic [BYTE_W-1:0] odd_par_byte(input logic [BYTE_W-2:0] code);
    return {~^code, code};
  endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  vpp_hi_i,
  input  logic  id_hi_i,
  output mode_e mode_o
);
  always_comb begin
    if (ce_ni)         mode_o = vpp_hi_i ? MODE_INHIBIT : MODE_STANDBY;
    else if (vpp_hi_i) mode_o = MODE_PROGRAM;
    else if (oe_ni)    mode_o = MODE_OUT_OFF;
    else if (id_hi_i)  mode_o = MODE_ID;
    else               mode_o = MODE_READ;
  end
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
  import otp_pkg::*;
#(
  parameter logic [BYTE_W-2:0] MFR_CODE = 7'h2A,
  parameter logic [BYTE_W-2:0] DEV_CODE = 7'h11
) (
  input  logic [1:0]        sel_i,
  output logic [BYTE_W-1:0] id_o
);
  localparam logic [BYTE_W-1:0] MfrByte = odd_par_byte(MFR_CODE);
  localparam logic [BYTE_W-1:0] DevByte = odd_par_byte(DEV_CODE);

  always_comb begin
    if (!sel_i[1])    id_o = CONT_CODE;
    else if (sel_i[0]) id_o = DevByte;
    else               id_o = MfrByte;
  end
endmodule

// File: rtl/otp_prog_strobe.sv
module otp_prog_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_i,
  output logic wr_en_o
);
  logic prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b0;
    else         prog_q <= prog_i;
  end

  // one write per entry into program mode
  assign wr_en_o = prog_i & ~prog_q;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      // programming can only clear bits
      mem_q[addr_i] <= mem_q[addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[addr_i];
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int              ADDR_W   = 6,
  parameter logic [6:0]      MFR_CODE = 7'h2A,
  parameter logic [6:0]      DEV_CODE = 7'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hi_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              drive_o
);
  mode_e             mode;
  logic              wr_en;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] id_byte;

  otp_mode_decode u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hi_i  (id_hi_i),
    .mode_o   (mode)
  );

  otp_prog_strobe u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (mode == MODE_PROGRAM),
    .wr_en_o (wr_en)
  );

  otp_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en),
    .wr_data_i (data_i),
    .rd_data_o (rd_data)
  );

  otp_id_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .sel_i (addr_i[1:0]),
    .id_o  (id_byte)
  );

  always_comb begin
    unique case (mode)
      MODE_READ: begin drive_o = 1'b1; data_o = rd_data; end
      MODE_ID:   begin drive_o = 1'b1; data_o = id_byte; end
      default:   begin drive_o = 1'b0; data_o = '0;      end
    endcase
  end
endmodule

// File: rtl/otp_byte_mem_chk.sv
module otp_byte_mem_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              vpp_hi_i,
  input logic              id_hi_i,
  input logic [7:0]        data_i,
  input logic [7:0]        data_o,
  input logic              drive_o,
  input logic              wr_en,
  input logic [7:0]        rd_data
);
  p_standby_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !drive_o);

  p_undriven_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> data_o == 8'h00);

  p_oe_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni && !vpp_hi_i) |-> !drive_o);

  p_prog_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && vpp_hi_i) |-> !drive_o);

  p_and_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !id_hi_i) |=> ($stable(addr_i) -> rd_data == ($past(rd_data) & $past(data_i))));

  p_single_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);

  p_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && vpp_hi_i) |-> !wr_en);

  p_one_way_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(addr_i) |-> (rd_data & ~$past(rd_data)) == 8'h00);

  p_id_parity_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && id_hi_i && addr_i[1]) |-> ^data_o);
endmodule

bind otp_byte_mem otp_byte_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .ce_ni    (ce_ni),
  .oe_ni    (oe_ni),
  .vpp_hi_i (vpp_hi_i),
  .id_hi_i  (id_hi_i),
  .data_i   (data_i),
  .data_o   (data_o),
  .drive_o  (drive_o),
  .wr_en    (wr_en),
  .rd_data  (rd_data)
);

// File: tb/otp_byte_mem_test.sv
`timescale 1ns/1ps
module otp_byte_mem_test;
  localparam int ADDR_W = 6;

  typedef struct packed {
    logic       ce_n;
    logic       oe_n;
    logic       vpp;
    logic       idh;
    logic [5:0] addr;
    logic [7:0] din;
    logic       exp_drv;
    logic [7:0] exp_dat;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b1,8'hFF,4'd1},  // R1 erased
    '{1'b1,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b0,8'h00,4'd3},  // R3 standby, oe low
    '{1'b1,1'b1,1'b0,1'b0,6'd5, 8'h00,1'b0,8'h00,4'd3},  // R3 standby, oe high
    '{1'b0,1'b1,1'b0,1'b0,6'd5, 8'h00,1'b0,8'h00,4'd4},  // R4 output off
    '{1'b1,1'b1,1'b1,1'b0,6'd5, 8'h00,1'b0,8'h00,4'd7},  // R7 inhibited strobe
    '{1'b0,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b1,8'hFF,4'd7},  // R7 nothing written
    '{1'b0,1'b1,1'b1,1'b0,6'd5, 8'hA5,1'b0,8'h00,4'd5},  // R5 program
    '{1'b0,1'b1,1'b1,1'b0,6'd5, 8'h00,1'b0,8'h00,4'd6},  // R6 held strobe
    '{1'b0,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b1,8'hA5,4'd6},  // R6 only first write
    '{1'b0,1'b1,1'b1,1'b0,6'd5, 8'hFF,1'b0,8'h00,4'd8},  // R8 program ones
    '{1'b0,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b1,8'hA5,4'd8},  // R8 unchanged
    '{1'b0,1'b1,1'b1,1'b0,6'd5, 8'h0F,1'b0,8'h00,4'd8},  // R8 partial mask
    '{1'b0,1'b0,1'b0,1'b0,6'd5, 8'h00,1'b1,8'h05,4'd8},  // R8 AND result
    '{1'b0,1'b0,1'b0,1'b0,6'd6, 8'h00,1'b1,8'hFF,4'd2},  // R2 neighbour untouched
    '{1'b0,1'b0,1'b0,1'b1,6'd2, 8'h00,1'b1,8'h2A,4'd9},  // R9 manufacturer
    '{1'b0,1'b0,1'b0,1'b1,6'd3, 8'h00,1'b1,8'h91,4'd9},  // R9 device
    '{1'b0,1'b0,1'b0,1'b1,6'd0, 8'h00,1'b1,8'h7F,4'd10}, // R10 continuation
    '{1'b0,1'b0,1'b0,1'b1,6'd1, 8'h00,1'b1,8'h7F,4'd10}, // R10 continuation
    '{1'b1,1'b0,1'b0,1'b1,6'd3, 8'h00,1'b0,8'h00,4'd3},  // R3 id but deselected
    '{1'b0,1'b0,1'b0,1'b0,6'd2, 8'h00,1'b1,8'hFF,4'd2}   // R2 read after id
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              vpp = 1'b0;
  logic              idh = 1'b0;
  logic [7:0]        din = '0;
  logic [7:0]        dout;
  logic              drv;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  otp_byte_mem #(.ADDR_W(ADDR_W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .ce_ni    (ce_n),
    .oe_ni    (oe_n),
    .vpp_hi_i (vpp),
    .id_hi_i  (idh),
    .data_i   (din),
    .data_o   (dout),
    .drive_o  (drv)
  );

  task automatic apply(input logic c, input logic o, input logic v, input logic i,
                       input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp = v; idh = i; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic edrv, input logic [7:0] edat);
    checks++;
    if (drv !== edrv || dout !== edat) begin
      fails++;
      $display("FAIL %s drive=%0b data=%02h expected drive=%0b data=%02h",
               req, drv, dout, edrv, edat);
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset state", 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].ce_n, VECS[k].oe_n, VECS[k].vpp, VECS[k].idh,
            VECS[k].addr, VECS[k].din);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].exp_drv, VECS[k].exp_dat);
    end

    // R11: parity of identifier bytes
    apply(1'b0, 1'b0, 1'b0, 1'b1, 6'd2, 8'h00);
    checks++;
    if (^dout !== 1'b1 || dout[6:0] !== 7'h2A) begin
      fails++; $display("FAIL R11 mfr byte=%02h expected odd parity over 2A", dout);
    end
    apply(1'b0, 1'b0, 1'b0, 1'b1, 6'd3, 8'h00);
    checks++;
    if (^dout !== 1'b1 || dout[6:0] !== 7'h11) begin
      fails++; $display("FAIL R11 dev byte=%02h expected odd parity over 11", dout);
    end

    // R5/R2 boundary addresses
    apply(1'b0, 1'b1, 1'b1, 1'b0, 6'd63, 8'h3C);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd63, 8'h00);
    check("R5 last address", 1'b1, 8'h3C);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 6'd0, 8'hC3);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00);
    check("R5 first address", 1'b1, 8'hC3);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd63, 8'h00);
    check("R2 last address kept", 1'b1, 8'h3C);

    // R6: reentry after leaving program mode writes again
    apply(1'b0, 1'b1, 1'b1, 1'b0, 6'd0, 8'hF0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 8'h00);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 6'd0, 8'h7F);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00);
    check("R6 reentry writes", 1'b1, 8'h40);

    // R1: reset erases programmed bytes
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00);
    check("R1 erase after reset addr0", 1'b1, 8'hFF);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
    check("R1 erase after reset addr5", 1'b1, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule